// File: doc/BRIEF.md
# Register Window Pointer Controller

This block holds the current window pointer of a processor whose registers are arranged as a circular set of windows. Each window has a bit in a window-invalid mask. The block serves four one-hot requests, one per cycle: save, restore, return-from-trap, and a status-word write. A separate mask write loads the invalid mask. For each move, the block computes the next pointer modulo a configurable window count, which need not be a power of two, and looks up the mask bit of the target window. It then either commits the move or reports a trap in the same cycle.

The trap report is a valid pulse with a 2-bit cause: 0 none, 1 window overflow, 2 window underflow, 3 illegal instruction. A packed status word is always readable. Its layout is: pointer in bits [4:0], enable-traps at bit 5, previous-supervisor at bit 6, supervisor at bit 7, interrupt level in bits [11:8], and FP-enable at bit 12. A status write uses the same layout.

Top module: `win_ptr_ctrl`

## Requirements
- R1: A save moves the pointer to pointer-1. From 0 it wraps to NWIN-1.
- R2: A restore moves the pointer to pointer+1. From NWIN-1 it wraps to 0.
- R3: If the mask bit of the save target is 1, the block reports trap cause 1 (overflow) and no state changes.
- R4: If the mask bit of the target (pointer+1, wrapped) is 1 for a restore or a return-from-trap, the block reports trap cause 2 (underflow) and no state changes.
- R5: A return-from-trap while enable-traps (bit 5) is 1 reports trap cause 3 (illegal) and no state changes.
- R6: A successful return-from-trap moves the pointer like a restore and copies previous-supervisor (bit 6) into supervisor (bit 7). Every other field is unchanged.
- R7: A status write whose pointer field [4:0] is below NWIN loads the pointer, enable-traps, previous-supervisor, supervisor, interrupt level and FP-enable fields from the written word.
- R8: A status write whose pointer field is NWIN or more reports trap cause 3 and changes nothing.
- R9: stat_o always shows the fields at the bit positions listed above.
- R10: A mask write replaces the whole mask and raises no trap.
- R11: trap_vld_o is driven in the same cycle as the request that causes it. It is never high without a request, and trap_type_o is 0 whenever it is low.
- R12: After reset, the pointer, the mask, enable-traps and all other flags are 0, except supervisor, which is 1 (stat_o = 0x080).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| save_i | input | 1 | Save request |
| restore_i | input | 1 | Restore request |
| rett_i | input | 1 | Return-from-trap request |
| stat_we_i | input | 1 | Status-word write request |
| stat_wdata_i | input | 13 | Status word to write |
| mask_we_i | input | 1 | Invalid-mask write |
| mask_wdata_i | input | NWIN | New invalid mask |
| stat_o | output | 13 | Packed status word |
| cwp_o | output | 5 | Current window pointer |
| trap_vld_o | output | 1 | Trap raised by this cycle's request |
| trap_type_o | output | 2 | Trap cause |

## Verification
A corrupted pointer or flag shows on stat_o one cycle after the request that wrote it. A bad wrap shows the same way, either as a value of NWIN or more or as a jump of more than one window. A wrong mask lookup shows at once on trap_vld_o and trap_type_o, because the trap report is combinational. A state update leaking through on a trapped request shows one cycle later as a stat_o value that differs from the value before the request. The bench steps the pointer through both wrap points with an odd window count, so an error that a power-of-two count would hide still shows.

// File: rtl/win_ptr_pkg.sv
package win_ptr_pkg;
  localparam int CWP_W   = 5;
  localparam int POS_ET  = 5;
  localparam int POS_PS  = 6;
  localparam int POS_S   = 7;
  localparam int POS_PIL = 8;
  localparam int PIL_W   = 4;
  localparam int POS_EF  = 12;
  localparam int STAT_W  = POS_EF + 1;

  typedef enum logic [1:0] {
    TRAP_NONE = 2'd0,
    TRAP_WOVF = 2'd1,
    TRAP_WUNF = 2'd2,
    TRAP_ILL  = 2'd3
  } trap_e;

  typedef struct packed {
    logic             ef;
    logic [PIL_W-1:0] pil;
    logic             s;
    logic             ps;
    logic             et;
  } flags_t;
endpackage

// File: rtl/win_ptr_step.sv
module win_ptr_step #(
  parameter int NWIN = 8
) (
  input  logic [win_ptr_pkg::CWP_W-1:0] cwp_i,
  output logic [win_ptr_pkg::CWP_W-1:0] dn_o,
  output logic [win_ptr_pkg::CWP_W-1:0] up_o
);
  import win_ptr_pkg::*;
  localparam logic [CWP_W-1:0] LAST = CWP_W'(NWIN - 1);

  // pointer is kept below NWIN, so one compare suffices for each wrap
  assign dn_o = (cwp_i == '0)   ? LAST : cwp_i - CWP_W'(1);
  assign up_o = (cwp_i == LAST) ? '0   : cwp_i + CWP_W'(1);
endmodule

// File: rtl/win_ptr_decide.sv
module win_ptr_decide #(
  parameter int NWIN = 8
) (
  input  logic                          save_i,
  input  logic                          restore_i,
  input  logic                          rett_i,
  input  logic                          stat_we_i,
  input  logic [win_ptr_pkg::STAT_W-1:0] stat_wdata_i,
  input  logic [win_ptr_pkg::CWP_W-1:0] dn_i,
  input  logic [win_ptr_pkg::CWP_W-1:0] up_i,
  input  logic [NWIN-1:0]               mask_i,
  input  win_ptr_pkg::flags_t           flags_i,
  output logic                          trap_vld_o,
  output win_ptr_pkg::trap_e            trap_type_o,
  output logic                          cwp_we_o,
  output logic [win_ptr_pkg::CWP_W-1:0] cwp_nxt_o,
  output logic                          flags_we_o,
  output win_ptr_pkg::flags_t           flags_nxt_o
);
  import win_ptr_pkg::*;
  localparam int MASK_EXT = 1 << CWP_W;

  logic [MASK_EXT-1:0] mask_ext;
  logic [CWP_W-1:0]    wr_cwp;
  logic                wr_ok;
  logic                dn_bad, up_bad;

  assign mask_ext = MASK_EXT'(mask_i);
  assign dn_bad   = mask_ext[dn_i];
  assign up_bad   = mask_ext[up_i];
  assign wr_cwp   = stat_wdata_i[CWP_W-1:0];
  assign wr_ok    = {1'b0, wr_cwp} < (CWP_W+1)'(NWIN);

  always_comb begin
    trap_vld_o  = 1'b0;
    trap_type_o = TRAP_NONE;
    cwp_we_o    = 1'b0;
    cwp_nxt_o   = dn_i;
    flags_we_o  = 1'b0;
    flags_nxt_o = flags_i;
    if (save_i) begin
      if (dn_bad) begin
        trap_vld_o  = 1'b1;
        trap_type_o = TRAP_WOVF;
      end else begin
        cwp_we_o  = 1'b1;
        cwp_nxt_o = dn_i;
      end
    end else if (restore_i) begin
      if (up_bad) begin
        trap_vld_o  = 1'b1;
        trap_type_o = TRAP_WUNF;
      end else begin
        cwp_we_o  = 1'b1;
        cwp_nxt_o = up_i;
      end
    end else if (rett_i) begin
      if (flags_i.et) begin
        trap_vld_o  = 1'b1;
        trap_type_o = TRAP_ILL;
      end else if (up_bad) begin
        trap_vld_o  = 1'b1;
        trap_type_o = TRAP_WUNF;
      end else begin
        cwp_we_o      = 1'b1;
        cwp_nxt_o     = up_i;
        flags_we_o    = 1'b1;
        flags_nxt_o.s = flags_i.ps;
      end
    end else if (stat_we_i) begin
      if (!wr_ok) begin
        trap_vld_o  = 1'b1;
        trap_type_o = TRAP_ILL;
      end else begin
        cwp_we_o        = 1'b1;
        cwp_nxt_o       = wr_cwp;
        flags_we_o      = 1'b1;
        flags_nxt_o.et  = stat_wdata_i[POS_ET];
        flags_nxt_o.ps  = stat_wdata_i[POS_PS];
        flags_nxt_o.s   = stat_wdata_i[POS_S];
        flags_nxt_o.pil = stat_wdata_i[POS_PIL +: PIL_W];
        flags_nxt_o.ef  = stat_wdata_i[POS_EF];
      end
    end
  end
endmodule

// File: rtl/win_stat_pack.sv
module win_stat_pack (
  input  logic [win_ptr_pkg::CWP_W-1:0]  cwp_i,
  input  win_ptr_pkg::flags_t            flags_i,
  output logic [win_ptr_pkg::STAT_W-1:0] stat_o
);
  import win_ptr_pkg::*;
  always_comb begin
    stat_o                      = '0;
    stat_o[CWP_W-1:0]           = cwp_i;
    stat_o[POS_ET]              = flags_i.et;
    stat_o[POS_PS]              = flags_i.ps;
    stat_o[POS_S]               = flags_i.s;
    stat_o[POS_PIL +: PIL_W]    = flags_i.pil;
    stat_o[POS_EF]              = flags_i.ef;
  end
endmodule

// File: rtl/win_ptr_ctrl.sv
module win_ptr_ctrl #(
  parameter int NWIN = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           save_i,
  input  logic                           restore_i,
  input  logic                           rett_i,
  input  logic                           stat_we_i,
  input  logic [win_ptr_pkg::STAT_W-1:0] stat_wdata_i,
  input  logic                           mask_we_i,
  input  logic [NWIN-1:0]                mask_wdata_i,
  output logic [win_ptr_pkg::STAT_W-1:0] stat_o,
  output logic [win_ptr_pkg::CWP_W-1:0]  cwp_o,
  output logic                           trap_vld_o,
  output logic [1:0]                     trap_type_o
);
  import win_ptr_pkg::*;

  localparam flags_t FLAGS_RST = '{ef: 1'b0, pil: '0, s: 1'b1, ps: 1'b0, et: 1'b0};

  logic [CWP_W-1:0] cwp_q, cwp_nxt, dn, up;
  logic [NWIN-1:0]  mask_q;
  flags_t           flags_q, flags_nxt;
  logic             cwp_we, flags_we;
  trap_e            trap_type;

  win_ptr_step #(.NWIN(NWIN)) u_step (
    .cwp_i (cwp_q),
    .dn_o  (dn),
    .up_o  (up)
  );

  win_ptr_decide #(.NWIN(NWIN)) u_decide (
    .save_i       (save_i),
    .restore_i    (restore_i),
    .rett_i       (rett_i),
    .stat_we_i    (stat_we_i),
    .stat_wdata_i (stat_wdata_i),
    .dn_i         (dn),
    .up_i         (up),
    .mask_i       (mask_q),
    .flags_i      (flags_q),
    .trap_vld_o   (trap_vld_o),
    .trap_type_o  (trap_type),
    .cwp_we_o     (cwp_we),
    .cwp_nxt_o    (cwp_nxt),
    .flags_we_o   (flags_we),
    .flags_nxt_o  (flags_nxt)
  );

  win_stat_pack u_pack (
    .cwp_i   (cwp_q),
    .flags_i (flags_q),
    .stat_o  (stat_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q   <= '0;
      mask_q  <= '0;
      flags_q <= FLAGS_RST;
    end else begin
      if (cwp_we)    cwp_q   <= cwp_nxt;
      if (flags_we)  flags_q <= flags_nxt;
      if (mask_we_i) mask_q  <= mask_wdata_i;
    end
  end

  assign cwp_o       = cwp_q;
  assign trap_type_o = trap_type;
endmodule

// File: rtl/win_ptr_ctrl_chk.sv
module win_ptr_ctrl_chk #(
  parameter int NWIN = 8
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           save_i,
  input logic                           restore_i,
  input logic                           rett_i,
  input logic                           stat_we_i,
  input logic [win_ptr_pkg::STAT_W-1:0] stat_wdata_i,
  input logic [win_ptr_pkg::STAT_W-1:0] stat_o,
  input logic [win_ptr_pkg::CWP_W-1:0]  cwp_o,
  input logic                           trap_vld_o,
  input logic [1:0]                     trap_type_o
);
  localparam logic [4:0] LAST = 5'(NWIN - 1);

  AST_CWP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, cwp_o} < 6'(NWIN)) else $error("cwp out of range"); // R1

  AST_SAVE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_i && !trap_vld_o |=> cwp_o == (($past(cwp_o) == 5'd0) ? LAST : $past(cwp_o) - 5'd1))
    else $error("save step"); // R1

  AST_RESTORE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i && !save_i && !trap_vld_o |=> cwp_o == (($past(cwp_o) == LAST) ? 5'd0 : $past(cwp_o) + 5'd1))
    else $error("restore step"); // R2

  AST_TRAP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_vld_o |=> $stable(stat_o)) else $error("state moved on trap"); // R3

  AST_RETT_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rett_i && !save_i && !restore_i && stat_o[5] |-> trap_vld_o && trap_type_o == 2'd3)
    else $error("rett with traps enabled"); // R5

  AST_WR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_we_i && !save_i && !restore_i && !rett_i && ({1'b0, stat_wdata_i[4:0]} >= 6'(NWIN))
    |-> trap_vld_o && trap_type_o == 2'd3) else $error("bad pointer write"); // R8

  AST_TRAP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_vld_o |-> save_i || restore_i || rett_i || stat_we_i) else $error("trap w/o request"); // R11

  AST_TYPE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_vld_o |-> trap_type_o == 2'd0) else $error("type without valid"); // R11
endmodule

bind win_ptr_ctrl win_ptr_ctrl_chk #(.NWIN(NWIN)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .save_i       (save_i),
  .restore_i    (restore_i),
  .rett_i       (rett_i),
  .stat_we_i    (stat_we_i),
  .stat_wdata_i (stat_wdata_i),
  .stat_o       (stat_o),
  .cwp_o        (cwp_o),
  .trap_vld_o   (trap_vld_o),
  .trap_type_o  (trap_type_o)
);

// File: tb/win_ptr_ctrl_tb.sv
module win_ptr_ctrl_tb_top;
  localparam int NW = 7;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        save = 1'b0, restore = 1'b0, rett = 1'b0, stat_we = 1'b0, mask_we = 1'b0;
  logic [12:0] stat_wdata = '0;
  logic [NW-1:0] mask_wdata = '0;
  logic [12:0] stat;
  logic [4:0]  cwp;
  logic        trap_vld;
  logic [1:0]  trap_type;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_ptr_ctrl #(.NWIN(NW)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .save_i       (save),
    .restore_i    (restore),
    .rett_i       (rett),
    .stat_we_i    (stat_we),
    .stat_wdata_i (stat_wdata),
    .mask_we_i    (mask_we),
    .mask_wdata_i (mask_wdata),
    .stat_o       (stat),
    .cwp_o        (cwp),
    .trap_vld_o   (trap_vld),
    .trap_type_o  (trap_type)
  );

  typedef struct {
    string       tag;
    logic [2:0]  trap;
    logic [12:0] st;
  } exp_t;

  exp_t sbq[$];
  event req_ev;
  int   total = 0, bad = 0;
  bit   done = 0;

  int          m_cwp = 0;
  logic [NW-1:0] m_mask = '0;
  logic        m_et = 0, m_ps = 0, m_s = 1, m_ef = 0;
  logic [3:0]  m_pil = '0;

  function automatic logic [12:0] pack();
    return {m_ef, m_pil, m_s, m_ps, m_et, 5'(m_cwp)};
  endfunction

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp_v);
    end
  endtask

  // kind: 0 save, 1 restore, 2 rett, 3 status write, 4 mask write
  task automatic do_req(input int kind, input logic [12:0] data, input string tag);
    exp_t e;
    int   tgt;
    logic [2:0] tr;
    @(negedge clk);
    tr = 3'b000;
    case (kind)
      0: begin
        save = 1'b1;
        tgt = (m_cwp == 0) ? NW - 1 : m_cwp - 1;
        if (m_mask[tgt]) tr = 3'b101; else m_cwp = tgt;
      end
      1: begin
        restore = 1'b1;
        tgt = (m_cwp == NW - 1) ? 0 : m_cwp + 1;
        if (m_mask[tgt]) tr = 3'b110; else m_cwp = tgt;
      end
      2: begin
        rett = 1'b1;
        tgt = (m_cwp == NW - 1) ? 0 : m_cwp + 1;
        if (m_et) tr = 3'b111;
        else if (m_mask[tgt]) tr = 3'b110;
        else begin m_cwp = tgt; m_s = m_ps; end
      end
      3: begin
        stat_we = 1'b1; stat_wdata = data;
        if (int'(data[4:0]) >= NW) tr = 3'b111;
        else begin
          m_cwp = int'(data[4:0]); m_et = data[5]; m_ps = data[6];
          m_s = data[7]; m_pil = data[11:8]; m_ef = data[12];
        end
      end
      default: begin
        mask_we = 1'b1; mask_wdata = data[NW-1:0];
        m_mask = data[NW-1:0];
      end
    endcase
    e.tag = tag; e.trap = tr; e.st = pack();
    sbq.push_back(e);
    #1;
    -> req_ev;
    @(posedge clk);
    #2;
    save = 0; restore = 0; rett = 0; stat_we = 0; mask_we = 0;
  endtask

  initial begin : monitor
    exp_t it;
    forever begin
      @(req_ev);
      it = sbq.pop_front();
      check({it.tag, " trap"}, 13'({trap_vld, trap_type}), 13'(it.trap));
      @(posedge clk);
      #1;
      check({it.tag, " stat"}, stat, it.st);
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset stat", stat, 13'h080);
    check("R11 idle trap", 13'({trap_vld, trap_type}), 13'd0);
    do_req(0, '0, "R1 save wrap 0->6");
    do_req(0, '0, "R1 save 6->5");
    do_req(1, '0, "R2 restore 5->6");
    do_req(1, '0, "R2 restore wrap 6->0");
    do_req(4, 13'h040, "R10 mask bit6");
    do_req(0, '0, "R3 save blocked");
    do_req(1, '0, "R2 restore 0->1");
    do_req(4, 13'h004, "R10 mask replaced bit2");
    do_req(1, '0, "R4 restore blocked");
    do_req(2, '0, "R4 rett blocked");
    do_req(3, 13'h0527, "R8 write cwp=7 rejected");
    do_req(3, 13'h1944, "R7 R9 write cwp=4 pil=9 ef ps");
    do_req(2, '0, "R6 rett s<=ps");
    do_req(3, 13'h00a3, "R7 write et=1 cwp=3");
    do_req(2, '0, "R5 rett et set");
    do_req(3, 13'h0006, "R8 write cwp=6 boundary");
    do_req(0, '0, "R1 save from 6 after write");
    do_req(4, 13'h0000, "R10 mask clear");
    do_req(2, '0, "R6 rett 5->6");
    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule